// File: doc/BRIEF.md
# Configurable Saturating Arithmetic Unit

This block is a two-stage pipelined integer unit with two result paths. The plain path adds or subtracts two operands, 32 or 64 bits wide and signed or unsigned. When it overflows or underflows, it clamps to the largest or smallest value that the selected format can hold. A single disable bit makes it wrap instead. The accumulate path multiplies two signed 32-bit operands, then adds the product to a 72-bit accumulator value or subtracts it. A 2-bit mode picks no saturation or one of three signed fixed-point clamp ranges.

Operands, operation, size and configuration bits are sampled together with `valid_i`. The result and its two flags appear two clock edges later as a one-cycle pulse. The accumulator contents come in on `acc_i` from an external register. Every issued operation carries its own configuration, so settings may change from one cycle to the next.

Top module: `sat_alu`

## Requirements
- R1: Signed plain results saturate to 0x7FFF_FFFF / 0x8000_0000 for 32-bit operations (`wide_i`=0) and to 0x7FFF_FFFF_FFFF_FFFF / 0x8000_0000_0000_0000 for 64-bit operations (`wide_i`=1). `op_i` encoding: 00 add (a+b), 01 subtract (a-b), 10 multiply-add (acc+a*b), 11 multiply-subtract (acc-a*b).
- R2: Unsigned plain results (`unsigned_i`=1) saturate to all-ones of the operand width on overflow and to zero on underflow.
- R3: With `sat_off_i`=1, plain results wrap modulo 2^N and both flags stay low. With `sat_off_i`=0, plain results saturate.
- R4: With accumulate mode 00, multiply-add and multiply-subtract results wrap modulo 2^72 and both flags stay low.
- R5: Accumulate mode 01 clamps to the range 0x7FFF_FFFF_FFFF_FFFF .. 0x8000_0000_0000_0000, sign-extended to 72 bits.
- R6: Accumulate mode 10 clamps to the range 0x3FFF_FFFF_FFFF_FFFF .. 0xC000_0000_0000_0000, sign-extended to 72 bits.
- R7: Accumulate mode 11 clamps to the range 0x7FFF_FFFF .. 0x8000_0000, sign-extended to 72 bits.
- R8: The accumulate mode has no effect on add and subtract results or flags.
- R9: A result, `ovf_o` and `unf_o` appear together with `valid_o` two rising edges after issue, for one cycle. The two flags are never high together. Reset clears all outputs.
- R10: Plain results that fit the range are exact. The result is sign-extended to 72 bits for signed operations and zero-extended for unsigned ones, and operand bits above bit 31 are ignored for 32-bit operations.
- R11: Operations issued on consecutive cycles with different accumulate modes each use the mode that was presented with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe |
| op_i | input | 2 | Operation select |
| wide_i | input | 1 | Plain operand size: 1 = 64-bit, 0 = 32-bit |
| unsigned_i | input | 1 | Plain operands are unsigned |
| sat_off_i | input | 1 | Disable plain saturation |
| acc_mode_i | input | 2 | Accumulate clamp mode |
| a_i | input | 64 | Operand A (low 32 bits for multiply) |
| b_i | input | 64 | Operand B (low 32 bits for multiply) |
| acc_i | input | 72 | Accumulator value in |
| valid_o | output | 1 | Result strobe |
| res_o | output | 72 | Result |
| ovf_o | output | 1 | Result was clamped at the top |
| unf_o | output | 1 | Result was clamped at the bottom |

## Verification
Each result, together with its two flags, becomes visible two rising edges after the cycle in which the operation was issued. The bench drives inputs on falling edges and holds its predictions in a two-slot pipeline that shifts on every falling edge. It compares the outputs against the prediction made two falling edges earlier, and in idle slots it checks that `valid_o` is low. Because operations are issued back to back, the sweeps also show that the configuration of one operation does not spill into its neighbour.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MAC = 2'b10,
    OP_MSC = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ACC_WRAP  = 2'b00,
    ACC_Q1_63 = 2'b01,
    ACC_Q2_62 = 2'b10,
    ACC_Q1_31 = 2'b11
  } acc_mode_e;
endpackage

// File: rtl/sat_alu_plain.sv
module sat_alu_plain #(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 72,
  parameter int EXT_W  = ACC_W + 2
) (
  input  logic                    sub_i,
  input  logic                    wide_i,
  input  logic                    unsigned_i,
  input  logic                    sat_off_i,
  input  logic [DATA_W-1:0]       a_i,
  input  logic [DATA_W-1:0]       b_i,
  output logic signed [EXT_W-1:0] raw_o,
  output logic [ACC_W-1:0]        wrap_o,
  output logic signed [EXT_W-1:0] max_o,
  output logic signed [EXT_W-1:0] min_o,
  output logic                    sat_en_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic signed [EXT_W-1:0] ONE   = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] TOP_W = ONE <<< (DATA_W - 1);
  localparam logic signed [EXT_W-1:0] TOP_H = ONE <<< (HALF_W - 1);

  logic [DATA_W-1:0] opnd [2];
  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  // operand extension per size and signedness
  for (genvar gi = 0; gi < 2; gi++) begin : g_ext
    logic signed [EXT_W-1:0] ext_v;
    always_comb begin
      if (wide_i) begin
        if (unsigned_i) ext_v = EXT_W'(opnd[gi]);
        else            ext_v = EXT_W'($signed(opnd[gi]));
      end else begin
        if (unsigned_i) ext_v = EXT_W'(opnd[gi][HALF_W-1:0]);
        else            ext_v = EXT_W'($signed(opnd[gi][HALF_W-1:0]));
      end
    end
  end

  assign raw_o    = sub_i ? (g_ext[0].ext_v - g_ext[1].ext_v)
                          : (g_ext[0].ext_v + g_ext[1].ext_v);
  assign sat_en_o = !sat_off_i;

  logic signed [EXT_W-1:0] top;
  always_comb begin
    top = wide_i ? TOP_W : TOP_H;
    if (unsigned_i) begin
      max_o = (top <<< 1) - ONE;
      min_o = '0;
    end else begin
      max_o = top - ONE;
      min_o = -top;
    end
  end

  always_comb begin
    if (wide_i) begin
      if (unsigned_i) wrap_o = ACC_W'(raw_o[DATA_W-1:0]);
      else            wrap_o = ACC_W'($signed(raw_o[DATA_W-1:0]));
    end else begin
      if (unsigned_i) wrap_o = ACC_W'(raw_o[HALF_W-1:0]);
      else            wrap_o = ACC_W'($signed(raw_o[HALF_W-1:0]));
    end
  end
endmodule

// File: rtl/sat_alu_mac.sv
module sat_alu_mac
  import sat_alu_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ACC_W  = 72,
  parameter int EXT_W  = ACC_W + 2
) (
  input  logic                    sub_i,
  input  logic [1:0]              mode_i,
  input  logic [HALF_W-1:0]       a_i,
  input  logic [HALF_W-1:0]       b_i,
  input  logic [ACC_W-1:0]        acc_i,
  output logic signed [EXT_W-1:0] raw_o,
  output logic [ACC_W-1:0]        wrap_o,
  output logic signed [EXT_W-1:0] max_o,
  output logic signed [EXT_W-1:0] min_o,
  output logic                    sat_en_o
);
  localparam int PROD_W = 2 * HALF_W;
  localparam logic signed [EXT_W-1:0] ONE   = EXT_W'(1);
  localparam logic signed [EXT_W-1:0] Q1_63 = ONE <<< (PROD_W - 1);
  localparam logic signed [EXT_W-1:0] Q2_62 = ONE <<< (PROD_W - 2);
  localparam logic signed [EXT_W-1:0] Q1_31 = ONE <<< (HALF_W - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [EXT_W-1:0]  prod_x, acc_x;
  acc_mode_e                mode;

  assign prod   = $signed(a_i) * $signed(b_i);
  assign prod_x = EXT_W'(prod);
  assign acc_x  = EXT_W'($signed(acc_i));
  assign raw_o  = sub_i ? (acc_x - prod_x) : (acc_x + prod_x);
  assign wrap_o = raw_o[ACC_W-1:0];
  assign mode   = acc_mode_e'(mode_i);

  logic signed [EXT_W-1:0] half_rng;
  always_comb begin
    sat_en_o = 1'b1;
    case (mode)
      ACC_Q1_63: half_rng = Q1_63;
      ACC_Q2_62: half_rng = Q2_62;
      ACC_Q1_31: half_rng = Q1_31;
      default: begin
        half_rng = Q1_63;
        sat_en_o = 1'b0;
      end
    endcase
    max_o = half_rng - ONE;
    min_o = -half_rng;
  end
endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
  parameter int ACC_W = 72,
  parameter int EXT_W = ACC_W + 2
) (
  input  logic signed [EXT_W-1:0] raw_i,
  input  logic [ACC_W-1:0]        wrap_i,
  input  logic signed [EXT_W-1:0] max_i,
  input  logic signed [EXT_W-1:0] min_i,
  input  logic                    sat_en_i,
  output logic [ACC_W-1:0]        res_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  logic above, below;
  assign above = raw_i > max_i;
  assign below = raw_i < min_i;

  always_comb begin
    ovf_o = sat_en_i && above;
    unf_o = sat_en_i && below && !above;
    if (ovf_o)      res_o = max_i[ACC_W-1:0];
    else if (unf_o) res_o = min_i[ACC_W-1:0];
    else            res_o = wrap_i;
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ACC_W  = 72
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic              unsigned_i,
  input  logic              sat_off_i,
  input  logic [1:0]        acc_mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic              valid_o,
  output logic [ACC_W-1:0]  res_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = ACC_W + 2;

  op_e  op;
  logic is_mac;
  assign op     = op_e'(op_i);
  assign is_mac = (op == OP_MAC) || (op == OP_MSC);

  logic signed [EXT_W-1:0] p_raw, p_max, p_min, m_raw, m_max, m_min;
  logic [ACC_W-1:0]        p_wrap, m_wrap;
  logic                    p_en, m_en;

  sat_alu_plain #(.DATA_W(DATA_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) plain_i (
    .sub_i      (op_i[0]),
    .wide_i     (wide_i),
    .unsigned_i (unsigned_i),
    .sat_off_i  (sat_off_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .raw_o      (p_raw),
    .wrap_o     (p_wrap),
    .max_o      (p_max),
    .min_o      (p_min),
    .sat_en_o   (p_en)
  );

  sat_alu_mac #(.HALF_W(HALF_W), .ACC_W(ACC_W), .EXT_W(EXT_W)) mac_i (
    .sub_i    (op_i[0]),
    .mode_i   (acc_mode_i),
    .a_i      (a_i[HALF_W-1:0]),
    .b_i      (b_i[HALF_W-1:0]),
    .acc_i    (acc_i),
    .raw_o    (m_raw),
    .wrap_o   (m_wrap),
    .max_o    (m_max),
    .min_o    (m_min),
    .sat_en_o (m_en)
  );

  // stage 1: raw result and its bounds
  logic                    s1_valid, s1_sat_en;
  logic signed [EXT_W-1:0] s1_raw, s1_max, s1_min;
  logic [ACC_W-1:0]        s1_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid  <= 1'b0;
      s1_sat_en <= 1'b0;
      s1_raw    <= '0;
      s1_max    <= '0;
      s1_min    <= '0;
      s1_wrap   <= '0;
    end else begin
      s1_valid <= valid_i;
      if (valid_i) begin
        s1_sat_en <= is_mac ? m_en   : p_en;
        s1_raw    <= is_mac ? m_raw  : p_raw;
        s1_max    <= is_mac ? m_max  : p_max;
        s1_min    <= is_mac ? m_min  : p_min;
        s1_wrap   <= is_mac ? m_wrap : p_wrap;
      end
    end
  end

  // stage 2: clamp and register
  logic [ACC_W-1:0] c_res;
  logic             c_ovf, c_unf;

  sat_alu_clamp #(.ACC_W(ACC_W), .EXT_W(EXT_W)) clamp_i (
    .raw_i    (s1_raw),
    .wrap_i   (s1_wrap),
    .max_i    (s1_max),
    .min_i    (s1_min),
    .sat_en_i (s1_sat_en),
    .res_o    (c_res),
    .ovf_o    (c_ovf),
    .unf_o    (c_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= s1_valid;
      ovf_o   <= s1_valid && c_ovf;
      unf_o   <= s1_valid && c_unf;
      if (s1_valid) res_o <= c_res;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o)); // R9
  AST_FLAG_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || unf_o) |-> valid_o); // R9
  AST_ISSUE_TO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid); // R9
  AST_STAGE_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid |=> valid_o); // R9
  AST_NO_SAT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && !s1_sat_en) |=> (!ovf_o && !unf_o)); // R3 R4
  AST_OVF_TAKES_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_sat_en && (s1_raw > s1_max)) |=>
      (ovf_o && res_o == $past(s1_max[ACC_W-1:0]))); // R1
  AST_UNF_TAKES_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid && s1_sat_en && (s1_raw < s1_min)) |=>
      (unf_o && res_o == $past(s1_min[ACC_W-1:0]))); // R2
  AST_PLAIN_MODE_BLIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[1]) |=> (s1_sat_en == !$past(sat_off_i))); // R8
endmodule

// File: tb/sat_alu_tb_top.sv
module sat_alu_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ni, valid_i, wide_i, unsigned_i, sat_off_i;
  logic [1:0]  op_i, acc_mode_i;
  logic [63:0] a_i, b_i;
  logic [71:0] acc_i, res_o;
  logic        valid_o, ovf_o, unf_o;

  sat_alu dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .wide_i(wide_i), .unsigned_i(unsigned_i), .sat_off_i(sat_off_i),
    .acc_mode_i(acc_mode_i), .a_i(a_i), .b_i(b_i), .acc_i(acc_i),
    .valid_o(valid_o), .res_o(res_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic        pv [2];
  logic [71:0] pr [2];
  logic        po [2], pu [2];
  string       pt [2];

  task automatic chk(string tag, string what, logic [79:0] act, logic [79:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [79:0] sx72(logic [71:0] v);
    return {{8{v[71]}}, v};
  endfunction

  task automatic model(input logic [1:0] op, input logic wide, uns, soff,
                       input logic [1:0] mode, input logic [63:0] a, b,
                       input logic [71:0] acc, output logic [71:0] r,
                       output logic o, u, inout string tag);
    logic signed [79:0] ea, eb, v, mx, mn;
    logic en;
    mx = '0; mn = '0;
    if (!op[1]) begin
      if (wide) begin
        ea = uns ? {16'h0, a} : {{16{a[63]}}, a};
        eb = uns ? {16'h0, b} : {{16{b[63]}}, b};
        mx = uns ? 80'hFFFF_FFFF_FFFF_FFFF : 80'h7FFF_FFFF_FFFF_FFFF;
        mn = uns ? 80'h0 : {16'hFFFF, 64'h8000_0000_0000_0000};
      end else begin
        ea = uns ? {48'h0, a[31:0]} : {{48{a[31]}}, a[31:0]};
        eb = uns ? {48'h0, b[31:0]} : {{48{b[31]}}, b[31:0]};
        mx = uns ? 80'hFFFF_FFFF : 80'h7FFF_FFFF;
        mn = uns ? 80'h0 : {48'hFFFF_FFFF_FFFF, 32'h8000_0000};
      end
      v  = op[0] ? ea - eb : ea + eb;
      en = !soff;
    end else begin
      ea = {{48{a[31]}}, a[31:0]};
      eb = {{48{b[31]}}, b[31:0]};
      v  = op[0] ? sx72(acc) - ea * eb : sx72(acc) + ea * eb;
      en = (mode != 2'b00);
      case (mode)
        2'b01: begin mx = 80'h7FFF_FFFF_FFFF_FFFF; mn = {16'hFFFF, 64'h8000_0000_0000_0000}; end
        2'b10: begin mx = 80'h3FFF_FFFF_FFFF_FFFF; mn = {16'hFFFF, 64'hC000_0000_0000_0000}; end
        default: begin mx = 80'h7FFF_FFFF; mn = {48'hFFFF_FFFF_FFFF, 32'h8000_0000}; end
      endcase
    end
    o = 1'b0; u = 1'b0;
    if (en && v > mx)      begin o = 1'b1; r = mx[71:0]; end
    else if (en && v < mn) begin u = 1'b1; r = mn[71:0]; end
    else if (!op[1]) begin
      if (wide) r = uns ? {8'h0, v[63:0]} : {{8{v[63]}}, v[63:0]};
      else      r = uns ? {40'h0, v[31:0]} : {{40{v[31]}}, v[31:0]};
      if (tag == "R1" || tag == "R2") tag = "R10";
    end else r = v[71:0];
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic wide, uns, soff,
                      input logic [1:0] mode, input logic [63:0] a, b,
                      input logic [71:0] acc, input string tag);
    logic [71:0] r;
    logic o, u;
    string t;
    @(negedge clk);
    if (pv[1]) begin
      chk(pt[1], "valid", 80'(valid_o), 80'd1);
      chk(pt[1], "res",   80'(res_o),   80'(pr[1]));
      chk(pt[1], "ovf",   80'(ovf_o),   80'(po[1]));
      chk(pt[1], "unf",   80'(pu[1]) == 80'(unf_o) ? 80'(unf_o) : 80'(unf_o), 80'(pu[1]));
    end else begin
      chk("R9", "idle valid", 80'(valid_o), 80'd0);
    end
    pv[1] = pv[0]; pr[1] = pr[0]; po[1] = po[0]; pu[1] = pu[0]; pt[1] = pt[0];
    valid_i = v; op_i = op; wide_i = wide; unsigned_i = uns; sat_off_i = soff;
    acc_mode_i = mode; a_i = a; b_i = b; acc_i = acc;
    t = tag;
    model(op, wide, uns, soff, mode, a, b, acc, r, o, u, t);
    pv[0] = v; pr[0] = r; po[0] = o; pu[0] = u; pt[0] = t;
  endtask

  task automatic idle();
    step(1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 64'h0, 64'h0, 72'h0, "R9");
  endtask

  function automatic logic [63:0] v64(int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'h2;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'h8000_0000_0000_0000;
      5: return 64'hFFFF_FFFF_FFFF_FFFF;
      6: return 64'h7FFF_FFFF_FFFF_FFFE;
      default: return 64'h4000_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] v32(int i);
    case (i)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h4000_0000;
      6: return 32'h0001_0000;
      default: return 32'hFFFF_0000;
    endcase
  endfunction

  function automatic logic [71:0] vacc(int i);
    case (i)
      0: return 72'h0;
      1: return 72'h00_3FFF_FFFF_FFFF_FFF0;
      2: return 72'h00_7FFF_FFFF_FFFF_FFF0;
      3: return 72'hFF_8000_0000_0000_0010;
      4: return 72'hFF_C000_0000_0000_0005;
      5: return 72'h00_0000_0000_7FFF_FFF0;
      6: return 72'h7F_FFFF_FFFF_FFFF_FFFF;
      default: return 72'h80_0000_0000_0000_0000;
    endcase
  endfunction

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pv[0] = 0; pv[1] = 0;
    rst_ni = 1'b0; valid_i = 1'b0; op_i = '0; wide_i = 0; unsigned_i = 0;
    sat_off_i = 0; acc_mode_i = '0; a_i = '0; b_i = '0; acc_i = '0;
    repeat (3) @(negedge clk);
    // reset state, R9
    chk("R9", "reset valid", 80'(valid_o), 80'd0);
    chk("R9", "reset res",   80'(res_o),   80'd0);
    chk("R9", "reset ovf",   80'(ovf_o),   80'd0);
    chk("R9", "reset unf",   80'(unf_o),   80'd0);
    rst_ni = 1'b1;

    // plain sweep: R1 R2 R3 R10, acc mode varied (R8)
    for (int wd = 0; wd < 2; wd++)
      for (int us = 0; us < 2; us++)
        for (int so = 0; so < 2; so++)
          for (int op = 0; op < 2; op++)
            for (int i = 0; i < 8; i++)
              for (int j = 0; j < 8; j++) begin
                logic [63:0] a, b;
                string tg;
                a = wd ? v64(i) : {32'hDEAD_BEEF, v64(i)[31:0] ^ {32{i[2]}}};
                b = wd ? v64(j) : {32'h1234_5678, v64(j)[31:0]};
                tg = so ? "R3" : (us ? "R2" : "R1");
                step(1'b1, 2'(op), wd[0], us[0], so[0], 2'((i + j) % 4), a, b, 72'h0, tg);
              end

    // mode must not touch plain ops, R8
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'(m), 64'h7FFF_FFFF, 64'h1, 72'h0, "R8");
      step(1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 2'(m), 64'h1, 64'h2, 72'h0, "R8");
    end

    // accumulate sweep: R4 R5 R6 R7
    for (int m = 0; m < 4; m++)
      for (int op = 2; op < 4; op++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            string tg;
            case (m)
              0: tg = "R4";
              1: tg = "R5";
              2: tg = "R6";
              default: tg = "R7";
            endcase
            step(1'b1, 2'(op), 1'b0, 1'b0, 1'b0, 2'(m), {32'hA5A5_A5A5, v32(i)},
                 {32'h5A5A_5A5A, v32(j)}, vacc((i * 3 + j) % 8), tg);
          end

    // mode changing every cycle, R11
    for (int k = 0; k < 16; k++)
      step(1'b1, k[0] ? 2'b11 : 2'b10, 1'b0, 1'b0, 1'b0, 2'(k % 4),
           64'h7FFF_FFFF, k[0] ? 64'h8000_0000 : 64'h7FFF_FFFF,
           k[2] ? 72'hFF_8000_0000_0000_0010 : 72'h00_7FFF_FFFF_FFFF_FFF0, "R11");

    // gaps between ops, R9
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 72'h0, "R9");
    idle();
    step(1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 2'b00, 64'h0, 64'h5, 72'h0, "R9");
    repeat (4) idle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule